// File: doc/BRIEF.md
# Interrupt Request Priority and In-Service Tracker

This block is the interrupt-side core of an eight-input interrupt controller. It records level-sensitive request lines in a request register. It qualifies those requests with a mask supplied by the command decoder and flags a pending interrupt to the processor. Input 0 has the highest priority and input 7 the lowest.

When the processor acknowledges, the block returns an 8-bit vector. The vector is a programmable base plus the index of the winning input. In the same step the block moves that input from the request register into the in-service register.

End-of-interrupt strobes from the command decoder release in-service bits. A specific strobe releases the bit named by a 3-bit level field. A non-specific strobe releases the highest-priority bit that is set. The request and in-service registers are brought out so the decoder can read them back.

Top module: `irq_prio_core`

## Requirements
- R1: A request line that goes from low to high sets its bit in `irr_o` at the next clock edge. A line that is low clears its bit at the next clock edge.
- R2: An acknowledged input's request bit is cleared by the acknowledge. It is set again only after the line goes low and then high again.
- R3: `pending_o` is high exactly when some unmasked request bit (`irr_o & ~mask_i`) has an index strictly lower than every set bit of `isr_o`. A set in-service bit of equal or higher priority blocks it.
- R4: While `ack_i` is high and an unmasked request exists, `vector_o` equals `vec_base_i` plus the lowest unmasked requesting index, taken modulo 256.
- R5: An acknowledge with an unmasked request sets that input's bit in `isr_o` at the next edge.
- R6: An acknowledge with no unmasked request returns `vec_base_i + 7` and leaves `irr_o` and `isr_o` unchanged.
- R7: `eoi_spec_i` clears only `isr_o[eoi_level_i]`.
- R8: `eoi_nonspec_i` clears the lowest-numbered set bit of `isr_o`. With `isr_o` zero it has no effect.
- R9: If both EOI strobes are high in the same cycle, only the specific clear is applied.
- R10: After reset, `irr_o` and `isr_o` are zero and `pending_o` is low.
- R11: The mask affects only pending and acknowledge selection. A masked line is still recorded in `irr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Level-sensitive request lines, bit 0 highest priority |
| mask_i | input | 8 | Mask from the command decoder, 1 masks the input |
| vec_base_i | input | 8 | Programmed vector base |
| ack_i | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| eoi_spec_i | input | 1 | Specific end-of-interrupt strobe |
| eoi_nonspec_i | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_level_i | input | 3 | Level released by a specific EOI |
| pending_o | output | 1 | Interrupt pending to the processor |
| vector_o | output | 8 | Vector returned during acknowledge |
| irr_o | output | 8 | Request register readback |
| isr_o | output | 8 | In-service register readback |

## Verification
Requests are applied in several forms:
- Single lines and multi-line patterns such as 0x81, 0x0C and 0x0B. These separate true level tracking from sticky latching and show which index wins the acknowledge.
- A line held high across its own acknowledge. This shows that the request is not re-captured without a fresh rising edge.
- Mixtures of masked and unmasked lines. These distinguish mask gating of `pending_o` from gating of the request register itself.
- Requests of higher, equal and lower priority than the in-service bit. These expose an off-by-one in the blocking comparison.

A base of 0xF8 exercises vector wraparound. A three-deep in-service stack is then released by specific, non-specific and simultaneous strobes to check the clearing order.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned N_IRQ = 8;
  localparam int unsigned IDX_W = $clog2(N_IRQ);
  localparam int unsigned VEC_W = 8;

  typedef logic [N_IRQ-1:0] irq_bits_t;
  typedef logic [IDX_W-1:0] irq_idx_t;
  typedef logic [VEC_W-1:0] irq_vec_t;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned W = 8,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  bits_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o
);
  // lower index wins: scan from the top so the last hit is the lowest
  always_comb begin
    found_o  = 1'b0;
    idx_o    = '0;
    onehot_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits_i[i]) begin
        found_o  = 1'b1;
        idx_o    = IW'(i);
        onehot_o = W'(1) << i;
      end
    end
  end
endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] grant_i,
  output logic [W-1:0] irr_o
);
  logic [W-1:0] req_q;
  logic [W-1:0] rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      irr_o <= '0;
    end else begin
      req_q <= req_i;
      irr_o <= req_i & (irr_o | rise) & ~grant_i;
    end
  end
endmodule

// File: rtl/irq_isr_reg.sv
module irq_isr_reg #(
  parameter int unsigned W = 8,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  grant_i,
  input  logic          eoi_spec_i,
  input  logic          eoi_nonspec_i,
  input  logic [IW-1:0] eoi_level_i,
  input  logic [W-1:0]  isr_low_onehot_i,
  output logic [W-1:0]  isr_o
);
  logic [W-1:0] clr;

  always_comb begin
    clr = '0;
    if (eoi_spec_i)         clr = W'(1) << eoi_level_i;
    else if (eoi_nonspec_i) clr = isr_low_onehot_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= (isr_o & ~clr) | grant_i;
  end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_prio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] req_i,
  input  logic [7:0] mask_i,
  input  logic [7:0] vec_base_i,
  input  logic       ack_i,
  input  logic       eoi_spec_i,
  input  logic       eoi_nonspec_i,
  input  logic [2:0] eoi_level_i,
  output logic       pending_o,
  output logic [7:0] vector_o,
  output logic [7:0] irr_o,
  output logic [7:0] isr_o
);
  irq_bits_t irr, isr, live, grant, req_onehot, isr_onehot;
  irq_idx_t  req_idx, isr_idx;
  logic      req_found, isr_found;

  assign live = irr & ~mask_i;

  irq_lowest_pick #(.W(N_IRQ)) u_req_pick (
    .bits_i(live), .found_o(req_found), .idx_o(req_idx), .onehot_o(req_onehot)
  );

  irq_lowest_pick #(.W(N_IRQ)) u_isr_pick (
    .bits_i(isr), .found_o(isr_found), .idx_o(isr_idx), .onehot_o(isr_onehot)
  );

  assign grant = (ack_i && req_found) ? req_onehot : '0;

  irq_req_reg #(.W(N_IRQ)) u_req_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .grant_i(grant), .irr_o(irr)
  );

  irq_isr_reg #(.W(N_IRQ)) u_isr_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .grant_i(grant),
    .eoi_spec_i(eoi_spec_i), .eoi_nonspec_i(eoi_nonspec_i),
    .eoi_level_i(eoi_level_i), .isr_low_onehot_i(isr_onehot), .isr_o(isr)
  );

  // strictly higher priority than any in-service level
  assign pending_o = req_found && (!isr_found || (req_idx < isr_idx));
  assign vector_o  = req_found ? irq_vec_t'(vec_base_i + irq_vec_t'(req_idx))
                               : irq_vec_t'(vec_base_i + irq_vec_t'(N_IRQ - 1));
  assign irr_o = irr;
  assign isr_o = isr;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] req_i,
  input logic [7:0] mask_i,
  input logic [7:0] vec_base_i,
  input logic       ack_i,
  input logic       eoi_spec_i,
  input logic       eoi_nonspec_i,
  input logic [2:0] eoi_level_i,
  input logic       pending_o,
  input logic [7:0] vector_o,
  input logic [7:0] irr_o,
  input logic [7:0] isr_o
);
  logic no_eoi;
  logic [7:0] vec_off;
  assign no_eoi  = !eoi_spec_i && !eoi_nonspec_i;
  assign vec_off = vector_o - vec_base_i;

  assert_irr_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irr_o & ~$past(req_i)) == 8'h00);

  assert_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> (irr_o & ~mask_i) != 8'h00);

  assert_vec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (irr_o & ~mask_i) != 8'h00) |-> (vec_off < 8'd8 && irr_o[vec_off[2:0]]));

  assert_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && no_eoi && (irr_o & ~mask_i) != 8'h00) |=>
      ((isr_o & $past(isr_o)) == $past(isr_o) && isr_o != 8'h00));

  assert_spur_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && no_eoi && (irr_o & ~mask_i) == 8'h00) |=> isr_o == $past(isr_o));

  assert_spur_vec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (irr_o & ~mask_i) == 8'h00) |-> vec_off == 8'd7);

  assert_eoi_spec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_spec_i && !ack_i) |=> !isr_o[$past(eoi_level_i)]);

  assert_eoi_ns_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_nonspec_i && !eoi_spec_i && !ack_i && isr_o != 8'h00) |=>
      $countones(isr_o) + 1 == $countones($past(isr_o)));
endmodule

bind irq_prio_core irq_prio_core_chk u_chk (.*);

// File: tb/irq_prio_core_bench.sv
module irq_prio_core_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0, mask_i = '0, vec_base_i = '0;
  logic       ack_i = 1'b0, eoi_spec_i = 1'b0, eoi_nonspec_i = 1'b0;
  logic [2:0] eoi_level_i = '0;
  logic       pending_o;
  logic [7:0] vector_o, irr_o, isr_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  irq_prio_core u_irq_prio_core (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = '0; mask_i = '0; vec_base_i = '0;
    ack_i = 0; eoi_spec_i = 0; eoi_nonspec_i = 0; eoi_level_i = '0;
    step(); rst_ni = 1'b1; step();
  endtask

  task automatic ack_once();
    ack_i = 1; step(); ack_i = 0; #1;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R10 irr", irr_o, 8'h00);
    chk("R10 isr", isr_o, 8'h00);
    chk("R10 pending", {7'd0, pending_o}, 8'h00);
  endtask

  task automatic t_level();
    do_reset();
    req_i = 8'h81; step();
    chk("R1 rise", irr_o, 8'h81);
    req_i = 8'h01; step();
    chk("R1 low clears", irr_o, 8'h01);
    req_i = 8'h00; step();
    chk("R1 all low", irr_o, 8'h00);
  endtask

  task automatic t_ack();
    do_reset();
    vec_base_i = 8'hF8; req_i = 8'h0C; step();
    ack_i = 1; #1;
    chk("R4 vector wrap", vector_o, 8'hFA);
    step(); ack_i = 0; #1;
    chk("R5 isr set", isr_o, 8'h04);
    chk("R2 irr cleared", irr_o, 8'h08);
    step();
    chk("R2 held line not recaptured", irr_o, 8'h08);
    req_i = 8'h08; step(); req_i = 8'h0C; step();
    chk("R2 new edge recaptured", irr_o, 8'h0C);
  endtask

  task automatic t_pend();
    do_reset();
    req_i = 8'h10; step();
    chk("R3 pending idle", {7'd0, pending_o}, 8'h01);
    ack_once();
    chk("R3 blocked by self", {7'd0, pending_o}, 8'h00);
    req_i = 8'h12; step();
    chk("R3 higher prio pending", {7'd0, pending_o}, 8'h01);
    mask_i = 8'h02; #1;
    chk("R3 masked not pending", {7'd0, pending_o}, 8'h00);
    chk("R11 masked still in irr", irr_o, 8'h02);
    req_i = 8'h32; step();
    chk("R3 lower prio blocked", {7'd0, pending_o}, 8'h00);
    req_i = 8'h22; step(); req_i = 8'h32; step();
    chk("R3 equal prio blocked", {7'd0, pending_o}, 8'h00);
  endtask

  task automatic t_spur();
    do_reset();
    vec_base_i = 8'h40; mask_i = 8'h04; req_i = 8'h04; step();
    ack_i = 1; #1;
    chk("R6 spurious vector", vector_o, 8'h47);
    step(); ack_i = 0; #1;
    chk("R6 isr unchanged", isr_o, 8'h00);
    chk("R6 irr unchanged", irr_o, 8'h04);
  endtask

  task automatic t_eoi();
    do_reset();
    req_i = 8'h0B; step();
    ack_once(); ack_once(); ack_once();
    chk("R5 stacked isr", isr_o, 8'h0B);
    eoi_spec_i = 1; eoi_level_i = 3'd1; step(); eoi_spec_i = 0;
    chk("R7 specific", isr_o, 8'h09);
    eoi_nonspec_i = 1; step(); eoi_nonspec_i = 0;
    chk("R8 nonspecific lowest", isr_o, 8'h08);
    eoi_spec_i = 1; eoi_nonspec_i = 1; eoi_level_i = 3'd0; step();
    eoi_spec_i = 0; eoi_nonspec_i = 0;
    chk("R9 specific wins", isr_o, 8'h08);
    eoi_nonspec_i = 1; step();
    chk("R8 clears last", isr_o, 8'h00);
    step(); eoi_nonspec_i = 0;
    chk("R8 empty no effect", isr_o, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_level(); t_ack(); t_pend(); t_spur(); t_eoi();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule